// File: doc/BRIEF.md
# Address-Sequence Unlock Detector

This block sits beside the decode logic of an 8K-byte asynchronous SRAM-style port and watches for a fixed run of six reads. The run asks a separate save/restore engine either to copy the volatile array into nonvolatile storage or to copy it back. The chip enable arrives active low and already synchronised to the system clock. The block takes one sample of the 13-bit address and the write enable at each high-to-low transition of that enable. Holding enable low for many clocks counts as a single access.

Five fixed prefix reads must come first, in a set order. The sixth read then selects the operation by its address: one code selects save and another selects restore. A write, a read from an unexpected address, or an access while the engine is busy throws the progress away. The outputs are a one-clock save request, a one-clock restore request, and a one-clock flag that tells the memory array to discard the access it has just seen. Output enable is not an input, so it cannot affect the count.

Top module: `unlock_seq_detector`

## Requirements
- R1: After reset, storeReq, recallReq and ignoreCycle are all low.
- R2: Reads of 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 in that order, then a read of 0x0F0F, raise storeReq for exactly one clock. That clock begins at the edge which samples the sixth enable fall.
- R3: The same five prefix reads followed by a read of 0x0F0E raise recallReq for exactly one clock, with the same timing as R2.
- R4: An access is taken only where ceN is sampled high at one edge and low at the next. Address changes while ceN stays low are not counted as further accesses.
- R5: An access with weN low (a write) at the enable fall clears all progress. No request follows from that run, and this includes a write to 0x0F0F or 0x0F0E as the sixth access.
- R6: A read from an address other than the next expected one clears the progress, and no request follows.
- R7: A read of 0x0000 at any point, including directly after an abort or a completed prefix, counts as the first step of a new run.
- R8: storeReq and recallReq are never high together. Either one is raised only if engineIdle was high at the sampling edge. A run whose sixth read arrives while engineIdle is low raises no request and clears the progress.
- R9: ignoreCycle pulses for one clock for a sixth read that raises a request, and for any access seen while engineIdle is low. It stays low for ordinary reads and writes.
- R10: After a request is raised the progress returns to idle, so repeating the sixth read alone raises nothing.
- R11: A save request is raised whether or not writes took place before the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Synchronised active-low chip enable |
| weN | input | 1 | Active-low write enable, sampled at the enable fall |
| addr | input | 13 | Byte address, sampled at the enable fall |
| engineIdle | input | 1 | High while the save/restore engine is idle |
| storeReq | output | 1 | One-clock save request |
| recallReq | output | 1 | One-clock restore request |
| ignoreCycle | output | 1 | One-clock flag: discard the access just seen |

## Verification
Clean runs that end in each of the two final codes separate the save path from the restore path. Runs broken by a write, by a wrong address, or by a busy engine show that an abort truly clears progress and is not merely delayed. A run that restarts with 0x0000 in the middle shows that a restart is not treated as an abort. A run where the enable is held low while the address steps through the whole list separates edge counting from level sampling. Repeating the final read after a request, and starting a run after earlier writes, confirm that the progress returns to idle and that no write history gates a save.

// File: rtl/unlock_seq_pkg.sv
package unlock_seq_pkg;

  localparam int ADDR_W     = 13;
  localparam int PREFIX_LEN = 5;
  localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t STORE_CODE  = 13'h0F0F;
  localparam addr_t RECALL_CODE = 13'h0F0E;

  // Prefix reads, in the order they must arrive.
  function automatic addr_t prefixCode(input int idx);
    case (idx)
      0:       return 13'h0000;
      1:       return 13'h1555;
      2:       return 13'h0AAA;
      3:       return 13'h1FFF;
      default: return 13'h10F0;
    endcase
  endfunction

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic issueStore;
    logic issueRecall;
    logic squash;
  } ctrlStrobe_t;

endpackage

// File: rtl/unlock_seq_datapath.sv
module unlock_seq_datapath
  import unlock_seq_pkg::*;
#(
  parameter int NUM_PREFIX = PREFIX_LEN
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ceN,
  input  logic                  weN,
  input  addr_t                 addr,
  input  ctrlStrobe_t           strobe,
  output logic                  ceFall,
  output logic                  isWrite,
  output logic [NUM_PREFIX-1:0] prefixHit,
  output logic                  storeHit,
  output logic                  recallHit,
  output logic                  storeReq,
  output logic                  recallReq,
  output logic                  ignoreCycle
);

  logic ceNq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ceNq <= 1'b1;
    else       ceNq <= ceN;
  end

  assign ceFall  = ceNq & ~ceN;
  assign isWrite = ~weN;

  for (genvar g = 0; g < NUM_PREFIX; g++) begin : g_prefix_cmp
    assign prefixHit[g] = (addr == prefixCode(g));
  end

  assign storeHit  = (addr == STORE_CODE);
  assign recallHit = (addr == RECALL_CODE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storeReq    <= 1'b0;
      recallReq   <= 1'b0;
      ignoreCycle <= 1'b0;
    end else begin
      storeReq    <= strobe.issueStore;
      recallReq   <= strobe.issueRecall;
      ignoreCycle <= strobe.squash;
    end
  end

  // R8: the two requests are exclusive.
  p_exclusive_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(storeReq && recallReq));

  // R2: a save request lasts one clock.
  p_store_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |=> !storeReq);

  // R3: a restore request lasts one clock.
  p_recall_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |=> !recallReq);

  // R4: a request only follows a sampled enable fall.
  p_req_after_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq || recallReq) |-> $past(ceFall));

  // R9: the access that raises a request is also marked for discard.
  p_req_marks_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq || recallReq) |-> ignoreCycle);

endmodule

// File: rtl/unlock_seq_control.sv
module unlock_seq_control
  import unlock_seq_pkg::*;
#(
  parameter int NUM_PREFIX = PREFIX_LEN,
  localparam int SW = $clog2(NUM_PREFIX + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ceFall,
  input  logic                  isWrite,
  input  logic [NUM_PREFIX-1:0] prefixHit,
  input  logic                  storeHit,
  input  logic                  recallHit,
  input  logic                  engineIdle,
  output ctrlStrobe_t           strobe
);

  logic [SW-1:0] step, nextStep;
  logic          atFinal;
  logic          expectHit;

  assign atFinal = (step == SW'(NUM_PREFIX));

  always_comb begin
    expectHit = 1'b0;
    for (int k = 0; k < NUM_PREFIX; k++) begin
      if (step == SW'(k)) expectHit = prefixHit[k];
    end
  end

  always_comb begin
    nextStep = step;
    strobe   = '0;
    if (ceFall) begin
      if (!engineIdle) begin
        strobe.squash = 1'b1;
        nextStep      = '0;
      end else if (isWrite) begin
        nextStep = '0;
      end else if (atFinal && storeHit) begin
        strobe.issueStore = 1'b1;
        strobe.squash     = 1'b1;
        nextStep          = '0;
      end else if (atFinal && recallHit) begin
        strobe.issueRecall = 1'b1;
        strobe.squash      = 1'b1;
        nextStep           = '0;
      end else if (expectHit) begin
        nextStep = step + SW'(1);
      end else if (prefixHit[0]) begin
        nextStep = SW'(1);
      end else begin
        nextStep = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) step <= '0;
    else       step <= nextStep;
  end

  // R4: progress moves only at a sampled enable fall.
  p_step_on_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(step) |-> $past(ceFall));

  // R5: a write leaves the progress at idle.
  p_write_abort_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ceFall && isWrite) |=> (step == '0));

  // R8: a busy engine clears progress.
  p_busy_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ceFall && !engineIdle) |=> (step == '0));

  // R10: the progress never runs past the final step.
  p_step_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    step <= SW'(NUM_PREFIX));

endmodule

// File: rtl/unlock_seq_detector.sv
module unlock_seq_detector
  import unlock_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              engineIdle,
  output logic              storeReq,
  output logic              recallReq,
  output logic              ignoreCycle
);

  ctrlStrobe_t           strobe;
  logic                  ceFall;
  logic                  isWrite;
  logic [PREFIX_LEN-1:0] prefixHit;
  logic                  storeHit;
  logic                  recallHit;

  unlock_seq_datapath #(.NUM_PREFIX(PREFIX_LEN)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ceN         (ceN),
    .weN         (weN),
    .addr        (addr),
    .strobe      (strobe),
    .ceFall      (ceFall),
    .isWrite     (isWrite),
    .prefixHit   (prefixHit),
    .storeHit    (storeHit),
    .recallHit   (recallHit),
    .storeReq    (storeReq),
    .recallReq   (recallReq),
    .ignoreCycle (ignoreCycle)
  );

  unlock_seq_control #(.NUM_PREFIX(PREFIX_LEN)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .ceFall     (ceFall),
    .isWrite    (isWrite),
    .prefixHit  (prefixHit),
    .storeHit   (storeHit),
    .recallHit  (recallHit),
    .engineIdle (engineIdle),
    .strobe     (strobe)
  );

endmodule

// File: tb/unlock_seq_detector_bench.sv
module unlock_seq_detector_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1;
  logic        weN = 1'b1;
  logic [12:0] addr = '0;
  logic        engineIdle = 1'b1;
  logic        storeReq, recallReq, ignoreCycle;

  int total = 0;
  int bad = 0;

  localparam logic [12:0] PRE [5] = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0};
  localparam logic [12:0] SAVE = 13'h0F0F;
  localparam logic [12:0] LOAD = 13'h0F0E;
  localparam logic [2:0]  NONE = 3'b000, GOT_STORE = 3'b101, GOT_RECALL = 3'b011, GOT_IGN = 3'b001;

  always #2 clk = ~clk;

  unlock_seq_detector u_unlock_seq_detector (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .addr(addr),
    .engineIdle(engineIdle), .storeReq(storeReq), .recallReq(recallReq),
    .ignoreCycle(ignoreCycle)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One enable-controlled access; returns {storeReq,recallReq,ignoreCycle}
  // seen in the clock after the fall, and checks that they drop again.
  task automatic access(input logic [12:0] a, input bit wr, output logic [2:0] seen);
    @(negedge clk);
    addr = a; weN = ~wr; ceN = 1'b0;
    @(negedge clk);
    seen = {storeReq, recallReq, ignoreCycle};
    ceN = 1'b1; weN = 1'b1;
    @(negedge clk);
    check({storeReq, recallReq, ignoreCycle} == 3'b000, "R8", "one-clock pulse",
          {storeReq, recallReq, ignoreCycle}, 0);
  endtask

  task automatic expectRead(input logic [12:0] a, input logic [2:0] exp, input string req);
    logic [2:0] s;
    access(a, 1'b0, s);
    check(s == exp, req, "outputs after read", s, exp);
  endtask

  task automatic prefixFrom(input int first);
    for (int k = first; k < 5; k++) expectRead(PRE[k], NONE, "R2");
  endtask

  task automatic t_reset;
    check({storeReq, recallReq, ignoreCycle} == 3'b000, "R1", "reset outputs",
          {storeReq, recallReq, ignoreCycle}, 0);
  endtask

  task automatic t_store;
    prefixFrom(0);
    expectRead(SAVE, GOT_STORE, "R2");
  endtask

  task automatic t_recall;
    prefixFrom(0);
    expectRead(LOAD, GOT_RECALL, "R3");
  endtask

  task automatic t_held_low;
    @(negedge clk);
    addr = PRE[0]; weN = 1'b1; ceN = 1'b0;
    for (int k = 1; k < 5; k++) begin
      @(negedge clk);
      check({storeReq, recallReq} == 2'b00, "R4", "no request while held", {storeReq, recallReq}, 0);
      addr = PRE[k];
    end
    @(negedge clk);
    addr = SAVE;
    @(negedge clk);
    @(negedge clk);
    check({storeReq, recallReq} == 2'b00, "R4", "held low final", {storeReq, recallReq}, 0);
    ceN = 1'b1;
    @(negedge clk);
    // Only the first step counted, so steps two to six complete a run.
    prefixFrom(1);
    expectRead(SAVE, GOT_STORE, "R4");
  endtask

  task automatic t_write_abort;
    logic [2:0] s;
    expectRead(PRE[0], NONE, "R5");
    expectRead(PRE[1], NONE, "R5");
    access(PRE[2], 1'b1, s);
    check(s == NONE, "R5", "write mid-run", s, NONE);
    for (int k = 2; k < 5; k++) expectRead(PRE[k], NONE, "R5");
    expectRead(SAVE, NONE, "R5");
    prefixFrom(0);
    access(SAVE, 1'b1, s);
    check(s == NONE, "R5", "write as sixth", s, NONE);
    expectRead(SAVE, NONE, "R5");
  endtask

  task automatic t_mismatch;
    expectRead(PRE[0], NONE, "R6");
    expectRead(PRE[1], NONE, "R6");
    expectRead(13'h0AAB, NONE, "R6");
    expectRead(PRE[3], NONE, "R6");
    expectRead(PRE[4], NONE, "R6");
    expectRead(SAVE, NONE, "R6");
  endtask

  task automatic t_restart;
    expectRead(PRE[0], NONE, "R7");
    expectRead(PRE[1], NONE, "R7");
    expectRead(PRE[0], NONE, "R7");
    prefixFrom(1);
    expectRead(LOAD, GOT_RECALL, "R7");
    prefixFrom(0);
    expectRead(PRE[0], NONE, "R7");
    prefixFrom(1);
    expectRead(SAVE, GOT_STORE, "R7");
  endtask

  task automatic t_busy;
    prefixFrom(0);
    engineIdle = 1'b0;
    expectRead(SAVE, GOT_IGN, "R8");
    engineIdle = 1'b1;
    expectRead(SAVE, NONE, "R8");
    engineIdle = 1'b0;
    expectRead(13'h1234, GOT_IGN, "R9");
    engineIdle = 1'b1;
    expectRead(13'h1234, NONE, "R9");
  endtask

  task automatic t_back_to_idle;
    t_store;
    expectRead(SAVE, NONE, "R10");
    expectRead(PRE[4], NONE, "R10");
    expectRead(LOAD, NONE, "R10");
  endtask

  task automatic t_prior_writes;
    logic [2:0] s;
    access(13'h0042, 1'b1, s);
    check(s == NONE, "R9", "plain write not ignored", s, NONE);
    access(13'h1000, 1'b1, s);
    prefixFrom(0);
    expectRead(SAVE, GOT_STORE, "R11");
  endtask

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rstN = 1'b1;
    @(negedge clk);
    t_reset;
    t_store;
    t_recall;
    t_held_low;
    t_write_abort;
    t_mismatch;
    t_restart;
    t_busy;
    t_back_to_idle;
    t_prior_writes;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule